// File: doc/BRIEF.md
# Privileged State Register Unit

This unit keeps four special registers of a 32-bit core with rotating register windows: the status word, the invalid-window mask, the trap base address and the upper-product register. A single request port reads or writes one of them per cycle. A write never takes a single operand. It stores the bitwise XOR of two source operands, which matches how the core forms these values from two register or immediate sources.

Every access is checked against the supervisor bit held in the status word. A forbidden access does not complete, and the unit raises a one-cycle trap request carrying an 8-bit trap type. The trap sequencer outside the unit takes that request from there. A status write that would set the current window pointer beyond the implemented windows is also refused. From the supervisor bit the unit derives the address-space identifiers for instruction fetches and data accesses. It also refuses floating-point operate instructions while the floating-point enable bit is clear.

Top module: `status_reg_unit`

## Requirements
- R1: A write that is allowed to complete stores op_a XOR op_b into the register chosen by req_sel (0 status word, 1 invalid-window mask, 2 trap base, 3 upper-product); the new value is visible on the register outputs after the next rising clock edge.
- R2: With the supervisor bit (status bit 7) clear, a read or write of select 0, 1 or 2 leaves all registers unchanged, drives rd_data to zero, and raises trap type 8'h03.
- R3: The invalid-window mask keeps only its low NWIN bits (7 by default); wmask_o bits above them read zero.
- R4: The trap base register keeps only bits 31:12 of the written value; bits 11:0 read zero.
- R5: A supervisor status write whose window-pointer field (bits 4:0 of op_a XOR op_b) is NWIN or more is discarded and raises trap type 8'h02; the privilege trap of R2 takes precedence.
- R6: imem_asi is 9 with the supervisor bit set and 8 with it clear; dmem_asi is 11 and 10 in the same cases.
- R7: fpop_valid without req_valid raises trap type 8'h04 when the FPU-enable bit (status bit 12) is clear, and raises no trap when it is set.
- R8: After reset the status word reads 32'h100000C0 (implementation 1, version 0, supervisor and previous-supervisor set, traps disabled, interrupt level 0, window 0), and the other three registers read zero.
- R9: The upper-product register (select 3) can be read and written at either privilege level, with no trap.
- R10: Status word layout: 31:28 implementation (constant IMPL), 27:24 version (constant VER), 23:20 condition codes, 19:14 reserved reading zero, 13 coprocessor enable, 12 FPU enable, 11:8 interrupt level, 7 supervisor, 6 previous supervisor, 5 trap enable, 4:0 window pointer; writes cannot change bits 31:14 other than 23:20.
- R11: trap_valid and trap_code are registered: they reflect the request of the previous cycle. A register request in the same cycle as fpop_valid wins, and the floating-point check is skipped. Allowed reads return the register combinationally on rd_data in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_sel | input | 2 | Register select: 0 status, 1 mask, 2 trap base, 3 upper-product |
| op_a | input | 32 | First write operand |
| op_b | input | 32 | Second write operand |
| fpop_valid | input | 1 | A floating-point operate instruction issues this cycle |
| rd_data | output | 32 | Read value, zero unless an allowed read |
| status_o | output | 32 | Current status word |
| wmask_o | output | 32 | Invalid-window mask, zero-extended |
| tbase_o | output | 32 | Trap base address |
| hi_o | output | 32 | Upper-product register |
| imem_asi | output | 8 | Instruction address-space identifier |
| dmem_asi | output | 8 | Data address-space identifier |
| trap_valid | output | 1 | Trap request for the previous cycle's access |
| trap_code | output | 8 | Trap type, zero when no trap |

## Verification
The properties assume every input is driven to a known value whenever reset is released. They also assume a floating-point issue counts as one only when no register request accompanies it. The stimulus sets all request fields at each falling edge and clears them after each operation. It steers most random status writes toward a legal window pointer and a set supervisor bit, so both privilege levels and both outcomes of the window check occur often. Periodic resets bring the core back to supervisor mode after it drops into user mode.

// File: rtl/sru_pkg.sv
package sru_pkg;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_WMASK  = 2'd1;
  localparam logic [1:0] SEL_TBASE  = 2'd2;
  localparam logic [1:0] SEL_HI     = 2'd3;

  localparam logic [7:0] TT_NONE    = 8'h00;
  localparam logic [7:0] TT_ILLEGAL = 8'h02;
  localparam logic [7:0] TT_PRIV    = 8'h03;
  localparam logic [7:0] TT_FPOFF   = 8'h04;

  localparam int BIT_SUP   = 7;
  localparam int BIT_PSUP  = 6;
  localparam int BIT_FPEN  = 12;

  // writable status bits: condition codes 23:20 and 13:0
  localparam logic [31:0] STATUS_WMASK = 32'h00F0_3FFF;

  function automatic logic [31:0] merge_ops(input logic [31:0] a, input logic [31:0] b);
    return a ^ b;
  endfunction

  function automatic logic [31:0] clean_status(input logic [31:0] raw,
                                               input logic [3:0]  impl,
                                               input logic [3:0]  ver);
    return {impl, ver, 24'h0} | (raw & STATUS_WMASK);
  endfunction

  function automatic logic [7:0] fetch_space(input logic sup);
    return sup ? 8'd9 : 8'd8;
  endfunction

  function automatic logic [7:0] data_space(input logic sup);
    return sup ? 8'd11 : 8'd10;
  endfunction

endpackage

// File: rtl/sru_gate.sv
module sru_gate
  import sru_pkg::*;
#(
  parameter int NWIN = 7
) (
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_sel,
  input  logic [4:0] new_cwp,
  input  logic       sup_bit,
  input  logic       fpen_bit,
  input  logic       fpop_valid,
  output logic       wr_status,
  output logic       wr_wmask,
  output logic       wr_tbase,
  output logic       wr_hi,
  output logic       rd_ok,
  output logic       trap_fire,
  output logic [7:0] trap_tt
);
  localparam logic [4:0] NWIN5 = 5'(NWIN);

  logic priv_fail, cwp_bad, fp_fail, wr_ok;

  assign priv_fail = req_valid && (req_sel != SEL_HI) && !sup_bit;
  assign cwp_bad   = req_valid && req_write && (req_sel == SEL_STATUS) && sup_bit
                     && (new_cwp >= NWIN5);
  assign fp_fail   = fpop_valid && !req_valid && !fpen_bit;

  assign wr_ok     = req_valid && req_write && !priv_fail && !cwp_bad;
  assign wr_status = wr_ok && (req_sel == SEL_STATUS);
  assign wr_wmask  = wr_ok && (req_sel == SEL_WMASK);
  assign wr_tbase  = wr_ok && (req_sel == SEL_TBASE);
  assign wr_hi     = wr_ok && (req_sel == SEL_HI);
  assign rd_ok     = req_valid && !req_write && !priv_fail;

  always_comb begin
    trap_fire = priv_fail || cwp_bad || fp_fail;
    if (priv_fail)    trap_tt = TT_PRIV;
    else if (cwp_bad) trap_tt = TT_ILLEGAL;
    else if (fp_fail) trap_tt = TT_FPOFF;
    else              trap_tt = TT_NONE;
  end
endmodule

// File: rtl/sru_status.sv
module sru_status
  import sru_pkg::*;
#(
  parameter logic [3:0] IMPL = 4'h1,
  parameter logic [3:0] VER  = 4'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_value,
  output logic [31:0] status_o
);
  localparam logic [31:0] RESET_WORD =
    {IMPL, VER, 24'h0} | (32'd1 << BIT_SUP) | (32'd1 << BIT_PSUP);

  logic [31:0] status_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     status_q <= RESET_WORD;
    else if (wr_en) status_q <= clean_status(wr_value, IMPL, VER);
  end

  assign status_o = status_q;
endmodule

// File: rtl/sru_side_regs.sv
module sru_side_regs #(
  parameter int NWIN   = 7,
  parameter int TB_LSB = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_wmask,
  input  logic        wr_tbase,
  input  logic        wr_hi,
  input  logic [31:0] wr_value,
  output logic [31:0] wmask_o,
  output logic [31:0] tbase_o,
  output logic [31:0] hi_o
);
  logic [NWIN-1:0]   wmask_q;
  logic [31:TB_LSB]  tbase_q;
  logic [31:0]       hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        wmask_q <= '0;
    else if (wr_wmask) wmask_q <= wr_value[NWIN-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        tbase_q <= '0;
    else if (wr_tbase) tbase_q <= wr_value[31:TB_LSB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_hi) hi_q <= wr_value;
  end

  generate
    if (NWIN < 32) begin : g_mask_pad
      assign wmask_o = {{(32-NWIN){1'b0}}, wmask_q};
    end else begin : g_mask_full
      assign wmask_o = wmask_q;
    end
  endgenerate

  assign tbase_o = {tbase_q, {TB_LSB{1'b0}}};
  assign hi_o    = hi_q;
endmodule

// File: rtl/status_reg_unit.sv
module status_reg_unit
  import sru_pkg::*;
#(
  parameter int         NWIN   = 7,
  parameter int         TB_LSB = 12,
  parameter logic [3:0] IMPL   = 4'h1,
  parameter logic [3:0] VER    = 4'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_sel,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        fpop_valid,
  output logic [31:0] rd_data,
  output logic [31:0] status_o,
  output logic [31:0] wmask_o,
  output logic [31:0] tbase_o,
  output logic [31:0] hi_o,
  output logic [7:0]  imem_asi,
  output logic [7:0]  dmem_asi,
  output logic        trap_valid,
  output logic [7:0]  trap_code
);
  logic [31:0] wr_value;
  logic        wr_status, wr_wmask, wr_tbase, wr_hi, rd_ok;
  logic        acc_trap;
  logic [7:0]  acc_tt;
  logic        trap_q;
  logic [7:0]  code_q;
  logic        sup_now;

  assign wr_value = merge_ops(op_a, op_b);
  assign sup_now  = status_o[BIT_SUP];

  sru_gate #(.NWIN(NWIN)) u_gate (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .new_cwp   (wr_value[4:0]),
    .sup_bit   (sup_now),
    .fpen_bit  (status_o[BIT_FPEN]),
    .fpop_valid(fpop_valid),
    .wr_status (wr_status),
    .wr_wmask  (wr_wmask),
    .wr_tbase  (wr_tbase),
    .wr_hi     (wr_hi),
    .rd_ok     (rd_ok),
    .trap_fire (acc_trap),
    .trap_tt   (acc_tt)
  );

  sru_status #(.IMPL(IMPL), .VER(VER)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_status),
    .wr_value(wr_value),
    .status_o(status_o)
  );

  sru_side_regs #(.NWIN(NWIN), .TB_LSB(TB_LSB)) u_side (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_wmask(wr_wmask),
    .wr_tbase(wr_tbase),
    .wr_hi   (wr_hi),
    .wr_value(wr_value),
    .wmask_o (wmask_o),
    .tbase_o (tbase_o),
    .hi_o    (hi_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      case (req_sel)
        SEL_STATUS: rd_data = status_o;
        SEL_WMASK:  rd_data = wmask_o;
        SEL_TBASE:  rd_data = tbase_o;
        default:    rd_data = hi_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      code_q <= TT_NONE;
    end else begin
      trap_q <= acc_trap;
      code_q <= acc_trap ? acc_tt : TT_NONE;
    end
  end

  assign trap_valid = trap_q;
  assign trap_code  = code_q;
  assign imem_asi   = fetch_space(sup_now);
  assign dmem_asi   = data_space(sup_now);
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int NWIN = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_sel,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        fpop_valid,
  input logic [31:0] status_o,
  input logic [31:0] wmask_o,
  input logic [31:0] tbase_o,
  input logic [31:0] hi_o,
  input logic [7:0]  imem_asi,
  input logic [7:0]  dmem_asi,
  input logic        trap_valid,
  input logic [7:0]  trap_code,
  input logic        acc_trap
);
  // R2: user-mode access to privileged registers changes nothing and traps
  a_r2_user_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel != 2'd3 && !status_o[7])
      |=> ($stable(status_o) && $stable(wmask_o) && $stable(tbase_o)
           && trap_valid && trap_code == 8'h03));

  // R3: mask bits above the window count stay zero
  a_r3_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask_o >> NWIN) == 32'd0);

  // R4: trap base low bits stay zero
  a_r4_base_align: assert property (@(posedge clk) disable iff (!rst_n)
    tbase_o[11:0] == 12'd0);

  // R5: window pointer never leaves the implemented range
  a_r5_cwp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[4:0] < 5'(NWIN));

  // R6: fetch and data identifiers move together
  a_r6_asi_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_asi == imem_asi + 8'd2) && (imem_asi[7:1] == 7'd4));

  // R7: floating-point op with FPU disabled traps next cycle
  a_r7_fp_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (fpop_valid && !req_valid && !status_o[12])
      |=> (trap_valid && trap_code == 8'h04));

  // R9: upper-product write works at any level
  a_r9_hi_any: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == 2'd3)
      |=> (hi_o == ($past(op_a) ^ $past(op_b)) && !trap_valid));

  // R10: reserved status bits read zero
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[19:14] == 6'd0);

  // R11: internal trap decision reaches the output one cycle later
  a_r11_trap_reg: assert property (@(posedge clk) disable iff (!rst_n)
    acc_trap |=> trap_valid);

  a_r11_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_trap |=> (!trap_valid && trap_code == 8'h00));
endmodule

bind status_reg_unit sru_checker #(.NWIN(NWIN)) u_sru_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_sel   (req_sel),
  .op_a      (op_a),
  .op_b      (op_b),
  .fpop_valid(fpop_valid),
  .status_o  (status_o),
  .wmask_o   (wmask_o),
  .tbase_o   (tbase_o),
  .hi_o      (hi_o),
  .imem_asi  (imem_asi),
  .dmem_asi  (dmem_asi),
  .trap_valid(trap_valid),
  .trap_code (trap_code),
  .acc_trap  (acc_trap)
);

// File: tb/test_status_reg_unit.sv
`timescale 1ns/1ps
module test_status_reg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, fpop_valid = 1'b0;
  logic [1:0]  req_sel = 2'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] rd_data, status_o, wmask_o, tbase_o, hi_o;
  logic [7:0]  imem_asi, dmem_asi, trap_code;
  logic        trap_valid;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [31:0] m_st, m_wm, m_tb, m_hi;

  always #4 clk = ~clk;

  status_reg_unit i_status_reg_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .op_a(op_a), .op_b(op_b), .fpop_valid(fpop_valid),
    .rd_data(rd_data), .status_o(status_o), .wmask_o(wmask_o), .tbase_o(tbase_o),
    .hi_o(hi_o), .imem_asi(imem_asi), .dmem_asi(dmem_asi),
    .trap_valid(trap_valid), .trap_code(trap_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [1:0] s);
    case (s)
      2'd0: return m_st;
      2'd1: return m_wm;
      2'd2: return m_tb;
      default: return m_hi;
    endcase
  endfunction

  task automatic compare_all();
    chk("R1/R10 status", status_o, m_st);
    chk("R1/R3 mask", wmask_o, m_wm);
    chk("R1/R4 base", tbase_o, m_tb);
    chk("R1/R9 upper", hi_o, m_hi);
    chk("R6 fetch asi", {24'h0, imem_asi}, m_st[7] ? 32'd9 : 32'd8);
    chk("R6 data asi", {24'h0, dmem_asi}, m_st[7] ? 32'd11 : 32'd10);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 0; req_write = 0; fpop_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_st = 32'h1000_00C0; m_wm = 0; m_tb = 0; m_hi = 0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_op(input bit v, input bit w, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] b, input bit fp);
    logic [31:0] x;
    bit sup, priv, bad, fpf, tr;
    logic [7:0] code;
    x    = a ^ b;
    sup  = m_st[7];
    priv = v && (s != 2'd3) && !sup;
    bad  = v && w && (s == 2'd0) && sup && (x[4:0] >= 5'd7);
    fpf  = fp && !v && !m_st[12];
    tr   = priv || bad || fpf;
    code = priv ? 8'h03 : (bad ? 8'h02 : (fpf ? 8'h04 : 8'h00));
    req_valid = v; req_write = w; req_sel = s; op_a = a; op_b = b; fpop_valid = fp;
    #1;
    if (v && !w) chk("R11/R2 read data", rd_data, priv ? 32'h0 : pick(s));
    @(negedge clk);
    if (v && w && !priv && !bad) begin
      case (s)
        2'd0: m_st = {4'h1, 4'h0, x[23:20], 6'b0, x[13:0]};
        2'd1: m_wm = {25'b0, x[6:0]};
        2'd2: m_tb = {x[31:12], 12'h000};
        default: m_hi = x;
      endcase
    end
    req_valid = 0; req_write = 0; fpop_valid = 0;
    chk("R11 trap valid", {31'b0, trap_valid}, {31'b0, tr});
    chk("R2/R5/R7 trap code", {24'b0, trap_code}, {24'b0, code});
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R8 reset state
    chk("R8 reset status", status_o, 32'h1000_00C0);
    chk("R8 reset mask", wmask_o, 32'h0);
    chk("R8 reset base", tbase_o, 32'h0);
    chk("R8 reset upper", hi_o, 32'h0);
    chk("R8 reset trap", {31'b0, trap_valid}, 32'h0);

    // R3 / R4 masking, R1 xor
    do_op(1, 1, 2'd1, 32'hFFFF_FF00, 32'h0000_00F0, 0);
    do_op(1, 1, 2'd2, 32'h1234_5678, 32'h0F0F_0F0F, 0);
    do_op(1, 0, 2'd2, 0, 0, 0);
    // R5 window pointer edges
    do_op(1, 1, 2'd0, 32'h0000_10C6, 32'h0, 0);
    do_op(1, 1, 2'd0, 32'h0000_10C7, 32'h0, 0);
    do_op(1, 1, 2'd0, 32'hFFFF_FFFF, 32'h0, 0);
    // R10 read-only fields
    do_op(1, 1, 2'd0, 32'hFFFF_FFC0, 32'h0000_0000, 0);
    do_op(1, 0, 2'd0, 0, 0, 0);
    // R7 FPU enabled (bit 12 set above): no trap
    do_op(0, 0, 2'd0, 0, 0, 1);
    do_op(1, 1, 2'd0, 32'h0000_00C1, 32'h0, 0);
    do_op(0, 0, 2'd0, 0, 0, 1);
    // R11 request wins over fpop
    do_op(1, 0, 2'd3, 0, 0, 1);
    // drop to user mode, R2 and R9
    do_op(1, 1, 2'd0, 32'h0000_0043, 32'h0, 0);
    do_op(1, 0, 2'd0, 0, 0, 0);
    do_op(1, 1, 2'd1, 32'h7F, 32'h0, 0);
    do_op(1, 1, 2'd2, 32'hFFFF_F000, 32'h0, 0);
    do_op(1, 1, 2'd3, 32'hDEAD_BEEF, 32'h0F0F_0000, 0);
    do_op(1, 0, 2'd3, 0, 0, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, want;
      if (i % 40 == 0) do_reset();
      a = $urandom;
      want = $urandom;
      if ($urandom % 4 != 0) want[4:0] = 5'($urandom % 7);
      if ($urandom % 4 != 0) want[7] = 1'b1;
      do_op(($urandom % 5) != 0, $urandom % 2, 2'($urandom), a, a ^ want,
            ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule